// File: doc/BRIEF.md
# Spread-spectrum switching-cycle oscillator with external lock

This block produces the cycle-start strobe that paces a PWM power stage. It counts system-clock ticks and restarts every `nom_period` ticks, so for a fixed system clock the nominal period maps onto a switching rate between 100 kHz and 1 MHz. The block works only in clock ticks. The nominal period, the dither depth and the triangle rate come from register inputs.

With dithering on, the period follows a slow symmetric triangle around the nominal value. This spreads the switching spectrum. The block can also lock to an external sync pulse train whose rate lies between 1.1 and 1.3 times the nominal rate. While locked, each valid sync pulse starts a new cycle, and `cur_period` reports the measured sync interval. The PWM block uses that interval to scale its maximum on-time. If the pulses stop, the block returns to its own timing.

Top module: `swcyc_osc`

## Requirements
- R1: While `rst_n` is low, `cyc_start`, `cur_period` and `sync_active` are all 0. The first clock edge after reset is released starts a cycle.
- R2: With dithering off and no lock, `cyc_start` is high for exactly one clock every `nom_period` clocks. `nom_period` is assumed to be at least 20.
- R3: With `dith_en` high, the period equals `nom_period + k`. The signed offset k moves by 1 per step, from 0 up to +L, then down to -L, then back up. Rising and falling therefore take the same number of steps, and the turning value is not repeated.
- R4: The dither limit L is the smaller of `dith_depth` and floor(`nom_period`/10). The period never leaves ±10 % of nominal.
- R5: The triangle takes one step every `tri_div` free-running cycle boundaries. A value of 0 acts as 1. While locked the triangle is frozen. When `dith_en` is low the offset is held at 0 and the triangle restarts rising.
- R6: A sync pulse is recognised on the clock edge at which the `sync_in` level has passed through a two-flop synchroniser and has been seen high for `SYNC_MIN_HI` consecutive clocks. A recognised pulse inside the window restarts the cycle on that edge and sets `sync_active`.
- R7: A recognised pulse is inside the window when the interval n, in clocks, since the previous recognised pulse satisfies 13·n ≥ 10·`nom_period` and 11·n ≤ 10·`nom_period`. A recognised pulse outside the window clears `sync_active` and does not restart the cycle. The first pulse after reset is always outside the window.
- R8: A `sync_in` pulse shorter than `SYNC_MIN_HI` clocks is ignored. The default of 7 clocks is about 50 ns at 125 MHz.
- R9: While locked, if the time since the last recognised pulse reaches `nom_period` + floor(`nom_period`/8) clocks, `sync_active` clears. Free-running cycles resume right after that.
- R10: `cur_period` changes only together with a cycle start. A change of `nom_period` or of the dither settings never shortens or stretches the cycle in progress.
- R11: While locked, `cur_period` equals the measured interval between the last two recognised sync pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nom_period | input | PW | Nominal cycle length in clocks |
| dith_en | input | 1 | Enables triangular period dither |
| dith_depth | input | PW | Requested dither amplitude in clocks |
| tri_div | input | RW | Free-running cycles per triangle step |
| sync_in | input | 1 | Asynchronous external sync pulse |
| cyc_start | output | 1 | One-clock strobe at the start of each cycle |
| cur_period | output | PW+1 | Length of the cycle now running, in clocks |
| sync_active | output | 1 | High while locked to the external sync |

## Verification
The bench targets the sync window edges. It drives intervals of 77 and 90 clocks, which must lock at a nominal period of 100, and 76 and 91 clocks, which must not. A design with an off-by-one in the window compare would lock at 76 or 91, or refuse 77 or 90. Pulses narrower than the qualification width are driven to catch a design that still restarts on glitches. A sync train that stops checks the fallback: a design without the timeout would stop producing strobes. A large depth request checks that the offset is clamped at ten percent, and a design that skips the clamp would give periods outside 90 to 110. A change of `nom_period` in the middle of a cycle exposes a design that applies period updates before the cycle boundary.

// File: rtl/swcyc_osc.sv
`timescale 1ns/1ps
module swcyc_osc #(
  parameter int PW = 16,
  parameter int RW = 16,
  parameter int SYNC_MIN_HI = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] nom_period,
  input  logic          dith_en,
  input  logic [PW-1:0] dith_depth,
  input  logic [RW-1:0] tri_div,
  input  logic          sync_in,
  output logic          cyc_start,
  output logic [PW:0]   cur_period,
  output logic          sync_active
);
  localparam int CW = PW + 1;
  localparam int TW = CW + 1;
  localparam int MW = PW + 6;
  localparam int HW = $clog2(SYNC_MIN_HI + 1);
  localparam logic signed [CW:0] ONE = 1;

  logic                 s1, s2;
  logic [HW-1:0]        hi;
  logic [CW-1:0]        gap, cnt, per_q;
  logic signed [CW:0]   ofs;
  logic                 up;
  logic [RW-1:0]        tcnt;

  wire [PW-1:0] tenth = nom_period / PW'(10);
  wire [PW-1:0] lim   = (dith_depth < tenth) ? dith_depth : tenth;
  wire signed [CW:0] lim_s = signed'({2'b00, lim});
  wire signed [CW:0] ofs_c = (ofs > lim_s) ? lim_s : ((ofs < -lim_s) ? -lim_s : ofs);
  wire signed [CW:0] nom_s = signed'({2'b00, nom_period});

  wire qual   = s2 && (hi == HW'(SYNC_MIN_HI - 1));
  wire [MW-1:0] nom10 = MW'(nom_period) * MW'(10);
  wire in_win = (MW'(gap) * MW'(13) >= nom10) && (MW'(gap) * MW'(11) <= nom10);
  wire tout   = sync_active && (TW'(gap) >= TW'(nom_period) + TW'(nom_period >> 3));
  wire sync_rst  = qual && in_win;
  wire free_wrap = !sync_active && ((TW'(cnt) + TW'(1)) >= TW'(per_q));
  wire restart   = sync_rst || free_wrap;
  wire tri_adv   = free_wrap && !sync_rst;
  wire step_now  = ({1'b0, tcnt} + (RW+1)'(1)) >= {1'b0, tri_div};

  assign cur_period = per_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      hi <= '0;
      gap <= '1;
    end else begin
      s1 <= sync_in;
      s2 <= s1;
      if (!s2) hi <= '0;
      else if (hi != HW'(SYNC_MIN_HI)) hi <= hi + 1'b1;
      if (qual) gap <= CW'(1);
      else if (gap != '1) gap <= gap + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      per_q <= '0;
      cyc_start <= 1'b0;
      sync_active <= 1'b0;
    end else begin
      cyc_start <= restart;
      if (restart) begin
        cnt <= '0;
        per_q <= sync_rst ? gap : CW'(nom_s + ofs_c);
      end else if (cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
      if (sync_rst) sync_active <= 1'b1;
      else if (qual || tout) sync_active <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ofs <= '0;
      up <= 1'b1;
      tcnt <= '0;
    end else if (!dith_en) begin
      ofs <= '0;
      up <= 1'b1;
      tcnt <= '0;
    end else if (tri_adv) begin
      if (!step_now) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        if (lim == '0) ofs <= '0;
        else if (up) begin
          if (ofs_c >= lim_s) begin up <= 1'b0; ofs <= ofs_c - ONE; end
          else ofs <= ofs_c + ONE;
        end else begin
          if (ofs_c <= -lim_s) begin up <= 1'b1; ofs <= ofs_c + ONE; end
          else ofs <= ofs_c - ONE;
        end
      end
    end
endmodule

// File: rtl/swcyc_osc_chk.sv
`timescale 1ns/1ps
module swcyc_osc_chk #(parameter int PW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] nom_period,
  input logic          cyc_start,
  input logic [PW:0]   cur_period,
  input logic          sync_active
);
  localparam int MW = PW + 6;
  wire [MW-1:0] per_x = MW'(cur_period);
  wire [MW-1:0] nom_x = MW'(nom_period);

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start);

  a_r10_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |-> $stable(cur_period));

  a_r4_dither_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !sync_active && $stable(nom_period)) |->
      (per_x * MW'(10) <= nom_x * MW'(11)) && (per_x * MW'(10) >= nom_x * MW'(9)));

  a_r7_sync_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && sync_active && $stable(nom_period)) |->
      (per_x * MW'(13) >= nom_x * MW'(10)) && (per_x * MW'(11) <= nom_x * MW'(10)));

  a_r6_lock_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_active) |-> cyc_start);
endmodule

bind swcyc_osc swcyc_osc_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .nom_period(nom_period),
  .cyc_start(cyc_start), .cur_period(cur_period), .sync_active(sync_active));

// File: tb/sim_swcyc_osc.sv
`timescale 1ns/1ps
module sim_swcyc_osc;
  localparam int PW = 16;
  localparam int RW = 16;
  localparam int MINHI = 7;
  localparam int GMAX = (1 << (PW + 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] nom_period = 16'd100;
  logic dith_en = 1'b0;
  logic [PW-1:0] dith_depth = '0;
  logic [RW-1:0] tri_div = 16'd1;
  logic sync_in = 1'b0;
  logic cyc_start;
  logic [PW:0] cur_period;
  logic sync_active;

  always #4 clk = ~clk;

  swcyc_osc u0 (
    .clk(clk), .rst_n(rst_n), .nom_period(nom_period), .dith_en(dith_en),
    .dith_depth(dith_depth), .tri_div(tri_div), .sync_in(sync_in),
    .cyc_start(cyc_start), .cur_period(cur_period), .sync_active(sync_active));

  int n_chk = 0, n_fail = 0;
  string req = "R1";

  task automatic check(input string r, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", r, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_s1, m_s2, m_hi, m_g, m_cnt, m_per, m_cs, m_act, m_ofs, m_up, m_tc;
  int nom, lim, oc, q, iw, to, sr, fw, td;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_hi = 0; m_g = GMAX; m_cnt = 0; m_per = 0;
      m_cs = 0; m_act = 0; m_ofs = 0; m_up = 1; m_tc = 0;
    end else begin
      nom = int'(nom_period);
      lim = (int'(dith_depth) < nom / 10) ? int'(dith_depth) : nom / 10;
      oc = m_ofs > lim ? lim : (m_ofs < -lim ? -lim : m_ofs);
      q = (m_s2 == 1 && m_hi == MINHI - 1) ? 1 : 0;
      iw = (m_g * 13 >= nom * 10 && m_g * 11 <= nom * 10) ? 1 : 0;
      to = (m_act == 1 && m_g >= nom + nom / 8) ? 1 : 0;
      sr = q & iw;
      fw = (m_act == 0 && m_cnt + 1 >= m_per) ? 1 : 0;
      td = (int'(tri_div) == 0) ? 1 : int'(tri_div);
      if (sr == 1 || fw == 1) begin
        m_cnt = 0; m_cs = 1; m_per = (sr == 1) ? m_g : nom + oc;
      end else begin
        m_cnt++; m_cs = 0;
      end
      if (!dith_en) begin
        m_ofs = 0; m_up = 1; m_tc = 0;
      end else if (fw == 1 && sr == 0) begin
        if (m_tc + 1 >= td) begin
          m_tc = 0;
          if (lim == 0) m_ofs = 0;
          else if (m_up == 1) begin
            if (oc >= lim) begin m_up = 0; m_ofs = oc - 1; end else m_ofs = oc + 1;
          end else begin
            if (oc <= -lim) begin m_up = 1; m_ofs = oc + 1; end else m_ofs = oc - 1;
          end
        end else m_tc++;
      end
      if (sr == 1) m_act = 1; else if (q == 1 || to == 1) m_act = 0;
      m_g = (q == 1) ? 1 : (m_g < GMAX ? m_g + 1 : m_g);
      m_hi = (m_s2 == 0) ? 0 : (m_hi < MINHI ? m_hi + 1 : m_hi);
      m_s2 = m_s1; m_s1 = int'(sync_in);
    end
  end

  always @(negedge clk) if (rst_n) begin
    check(req, int'(cyc_start), m_cs, "cyc_start vs model");
    check(req, int'(cur_period), m_per, "cur_period vs model");
    check(req, int'(sync_active), m_act, "sync_active vs model");
  end

  task automatic measure(output int iv);
    do @(negedge clk); while (!cyc_start);
    iv = 0;
    do begin @(negedge clk); iv++; end while (!cyc_start);
  endtask

  task automatic sync_train(input int per, input int wid, input int num);
    for (int i = 0; i < num; i++) begin
      sync_in = 1'b1;
      repeat (wid) @(negedge clk);
      sync_in = 1'b0;
      repeat (per - wid) @(negedge clk);
    end
  endtask

  task automatic window_case(input string r, input int per, input int exp_lock);
    int iv;
    req = r;
    fork
      sync_train(per, 8, 20);
      begin
        repeat (per * 12) @(negedge clk);
        check(r, int'(sync_active), exp_lock, $sformatf("lock at interval %0d", per));
        measure(iv);
        check(r, iv, exp_lock ? per : 100, $sformatf("strobe spacing, sync interval %0d", per));
      end
    join
    repeat (400) @(negedge clk);
  endtask

  task automatic dither_span(input string r, input int cycles, input int exp_lo, input int exp_hi);
    int lo, hi;
    lo = 1 << 20; hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (cyc_start) begin
        if (int'(cur_period) < lo) lo = int'(cur_period);
        if (int'(cur_period) > hi) hi = int'(cur_period);
      end
    end
    check(r, lo, exp_lo, "dither minimum period");
    check(r, hi, exp_hi, "dither maximum period");
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int iv;
    repeat (3) @(negedge clk);
    check("R1", int'(cyc_start), 0, "cyc_start in reset");
    check("R1", int'(cur_period), 0, "cur_period in reset");
    check("R1", int'(sync_active), 0, "sync_active in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(cyc_start), 1, "first strobe after reset");

    req = "R2";
    measure(iv);
    check("R2", iv, 100, "free-running spacing");
    nom_period = 16'd40;
    repeat (150) @(negedge clk);
    measure(iv);
    check("R2", iv, 40, "free-running spacing at 40");
    nom_period = 16'd100;
    repeat (200) @(negedge clk);

    req = "R10";
    do @(negedge clk); while (!cyc_start);
    iv = 0;
    do begin @(negedge clk); iv++; if (iv == 30) nom_period = 16'd60; end while (!cyc_start);
    check("R10", iv, 100, "cycle in progress keeps old length");
    measure(iv);
    check("R10", iv, 60, "new length applied at boundary");
    nom_period = 16'd100;
    repeat (200) @(negedge clk);

    req = "R3";
    dith_depth = 16'd5; tri_div = 16'd2; dith_en = 1'b1;
    dither_span("R3", 6000, 95, 105);
    req = "R5";
    dith_depth = 16'd3; tri_div = 16'd4;
    repeat (5000) @(negedge clk);
    tri_div = 16'd0;
    repeat (2000) @(negedge clk);
    req = "R4";
    dith_depth = 16'd50; tri_div = 16'd1;
    dither_span("R4", 6000, 90, 110);
    dith_en = 1'b0;
    repeat (300) @(negedge clk);
    measure(iv);
    check("R5", iv, 100, "offset cleared when dither off");

    window_case("R7", 77, 1);
    window_case("R7", 76, 0);
    window_case("R7", 90, 1);
    window_case("R7", 91, 0);

    req = "R6 R11";
    fork
      sync_train(80, 8, 20);
      begin
        repeat (900) @(negedge clk);
        measure(iv);
        check("R6", iv, 80, "strobe follows sync");
        check("R11", int'(cur_period), 80, "cur_period equals sync interval");
      end
    join
    req = "R9";
    repeat (400) @(negedge clk);
    check("R9", int'(sync_active), 0, "lock dropped after timeout");
    measure(iv);
    check("R9", iv, 100, "free running after timeout");

    req = "R8";
    fork
      sync_train(80, 3, 15);
      begin
        repeat (900) @(negedge clk);
        check("R8", int'(sync_active), 0, "narrow pulses ignored");
        measure(iv);
        check("R8", iv, 100, "spacing unchanged by narrow pulses");
      end
    join
    repeat (200) @(negedge clk);

    req = "R6";
    dith_en = 1'b1; dith_depth = 16'd8; tri_div = 16'd1;
    sync_train(85, 8, 20);
    repeat (400) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule